// File: doc/BRIEF.md
# Serial-Port DMA Interrupt Latch Controller

This block gathers completion events from twelve serial DMA channels, grouped as six ports with an A and a B channel each, and turns them into six port interrupts. The two channels of a port share one interrupt bit and one vector. Each port interrupt is latched into one of two 32-bit pending words, a primary word and a secondary word. Latching happens whether or not the port is masked. A per-bit enable then decides whether a pending bit may be serviced. The highest-priority serviceable port is offered to the core as a registered request with its vector address. The core answers with a one-cycle acknowledge.

Each channel runs in one of two modes, chosen by `dma_mode_i`. In DMA mode, a completion pulse counts only if the completion-interrupt enable of the current chained descriptor is set. This lets software silence the middle transfers of a chain. In core-driven mode, the completion pulse is ignored. Instead, the channel raises its port interrupt while its receive buffer holds data or its transmit buffer has room.

The request handshake is a three-state machine. From `S_IDLE` it moves to `S_REQ` when some pending bit is enabled; the winning port and its vector are captured on that transition. From `S_REQ` it moves to `S_GAP` on acknowledge, which clears the served pending bit. It falls back from `S_REQ` to `S_IDLE` if the served bit stops being serviceable, because it was cleared or masked. `S_GAP` always returns to `S_IDLE` after one cycle, so the next arbitration sees the cleared bit.

Top module: `serial_dma_irq_latch`

## Requirements
- R1: After reset every pending bit reads 0, every port is masked (enable 0) and `irq_o` is low.
- R2: Channels 2k and 2k+1 form pair k, and each pair drives one port: pair 0 drives port 1, pair 1 drives port 0, pair 2 drives port 3, pair 3 drives port 2, pair 4 drives port 5, and pair 5 drives port 4. Odd ports live in the primary word at bit 14 + (port/2). Even ports live in the secondary word at bit port/2.
- R3: The vector of an odd port is 0x38 + 4*(port/2). The vector of an even port is 0x44 + 4*(port/2).
- R4: An event sets its pending bit whether or not the port is enabled. A masked bit raises no request, and it is serviced once its enable bit is written to 1.
- R5: In DMA mode (`dma_mode_i` bit = 1), a completion pulse sets the pending bit only when the channel's `chain_ien_i` bit is 1.
- R6: In core-driven mode (`dma_mode_i` bit = 0), a channel raises its port interrupt while `rx_avail_i` or `tx_room_i` is high, and its completion pulse is ignored.
- R7: Events from any number of ports in the same cycle are all latched one cycle later.
- R8: Among pending, enabled ports, the lowest vector is served first.
- R9: An acknowledge while `irq_o` is high clears the served pending bit and drops `irq_o` in the next cycle.
- R10: A core write with `cfg_sel_i` = 2 clears the primary pending bits at the 1 positions of `cfg_wdata_i`; `cfg_sel_i` = 3 does the same for the secondary word. `cfg_sel_i` = 0 writes the primary enables and 1 writes the secondary enables, at the same bit positions. An event in the same cycle as a clear keeps its bit set.
- R11: `irq_o` rises exactly one cycle after a pending bit becomes serviceable while the controller is idle.
- R12: While `irq_o` is high and unacknowledged, `irq_vec_o` holds steady. If the served bit stops being serviceable, `irq_o` falls one cycle after the pending word shows the change.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_i | input | 1 | Synchronous active-high reset |
| dma_mode_i | input | 12 | Per channel: 1 = DMA mode, 0 = core-driven mode |
| done_i | input | 12 | Per-channel DMA completion pulse |
| chain_ien_i | input | 12 | Completion-interrupt enable of the current chained descriptor |
| rx_avail_i | input | 12 | Receive buffer holds data |
| tx_room_i | input | 12 | Transmit buffer is not full |
| cfg_we_i | input | 1 | Core write strobe |
| cfg_sel_i | input | 2 | 0 primary enable, 1 secondary enable, 2 primary clear, 3 secondary clear |
| cfg_wdata_i | input | 32 | Core write data |
| ack_i | input | 1 | Core acknowledge of the offered vector |
| irq_o | output | 1 | Registered interrupt request |
| irq_vec_o | output | 8 | Vector address of the offered interrupt |
| pend_pri_o | output | 32 | Primary pending word |
| pend_sec_o | output | 32 | Secondary pending word |

## Verification
The hardest case to reach is an event arriving on the same edge as a clear of its own bit. A plain pulse is gone before a later write can clear it. To get there, the bench holds a core-driven receive-available level high across the clear write, then drops it and clears again, so the second clear must succeed. A second hard case is a request withdrawn while it is being offered. The bench reaches it by leaving a request unacknowledged for several cycles and then clearing its bit through the core write path.

// File: rtl/dirq_pkg.sv
package dirq_pkg;

    localparam int N_CHAN       = 12;
    localparam int N_PORT       = N_CHAN / 2;
    localparam int REG_W        = 32;
    localparam int VEC_W        = 8;
    localparam int PRI_BASE     = 14;
    localparam int SEC_BASE     = 0;
    localparam int PRI_VEC_BASE = 'h38;
    localparam int SEC_VEC_BASE = 'h44;
    localparam int VEC_STEP     = 4;
    localparam int PORT_IDX_W   = $clog2(N_PORT);

    typedef enum logic [1:0] {
        CFG_EN_PRI  = 2'd0,
        CFG_EN_SEC  = 2'd1,
        CFG_CLR_PRI = 2'd2,
        CFG_CLR_SEC = 2'd3
    } cfg_sel_e;

    typedef enum logic [1:0] {
        S_IDLE = 2'd0,
        S_REQ  = 2'd1,
        S_GAP  = 2'd2
    } req_state_e;

    // Pair k feeds its neighbour port: even pairs go up one, odd pairs down one.
    function automatic int chan_to_port(input int c);
        int k;
        k = c / 2;
        return (k % 2 == 0) ? k + 1 : k - 1;
    endfunction

    function automatic bit port_in_primary(input int p);
        return (p % 2) == 1;
    endfunction

    function automatic int port_bit(input int p);
        return port_in_primary(p) ? PRI_BASE + p / 2 : SEC_BASE + p / 2;
    endfunction

    function automatic logic [VEC_W-1:0] port_vec(input int p);
        int v;
        v = port_in_primary(p) ? PRI_VEC_BASE + VEC_STEP * (p / 2)
                               : SEC_VEC_BASE + VEC_STEP * (p / 2);
        return VEC_W'(v);
    endfunction

    function automatic logic [REG_W-1:0] bank_used_mask(input bit primary);
        logic [REG_W-1:0] m;
        m = '0;
        for (int p = 0; p < N_PORT; p++) begin
            if (port_in_primary(p) == primary) m[port_bit(p)] = 1'b1;
        end
        return m;
    endfunction

endpackage

// File: rtl/dirq_event_merge.sv
module dirq_event_merge
    import dirq_pkg::*;
(
    input  logic              clk_i,
    input  logic              rst_i,
    input  logic [N_CHAN-1:0] dma_mode_i,
    input  logic [N_CHAN-1:0] done_i,
    input  logic [N_CHAN-1:0] chain_ien_i,
    input  logic [N_CHAN-1:0] rx_avail_i,
    input  logic [N_CHAN-1:0] tx_room_i,
    output logic [N_PORT-1:0] port_ev_o
);

    logic [N_CHAN-1:0] ch_ev;

    // Each channel picks its source by mode.
    for (genvar c = 0; c < N_CHAN; c++) begin : g_chan
        assign ch_ev[c] = dma_mode_i[c] ? (done_i[c] & chain_ien_i[c])
                                        : (rx_avail_i[c] | tx_room_i[c]);
    end

    // Both channels of a pair fold onto one port bit.
    always_comb begin
        port_ev_o = '0;
        for (int c = 0; c < N_CHAN; c++) begin
            if (ch_ev[c]) port_ev_o[chan_to_port(c)] = 1'b1;
        end
    end

    // Completion pulses with the descriptor enable cleared, or in core-driven
    // mode, must not reach a port on their own.
    AST_QUIET_COMPLETION: assert property (@(posedge clk_i) disable iff (rst_i)
        (((done_i & ~(dma_mode_i & chain_ien_i)) != '0) &&
         ((done_i & dma_mode_i & chain_ien_i) == '0) &&
         (((rx_avail_i | tx_room_i) & ~dma_mode_i) == '0))
        |-> (port_ev_o == '0)); // R5 R6

endmodule

// File: rtl/dirq_pending.sv
module dirq_pending
    import dirq_pkg::*;
(
    input  logic              clk_i,
    input  logic              rst_i,
    input  logic [N_PORT-1:0] port_ev_i,
    input  logic [N_PORT-1:0] ack_clr_i,
    input  logic              cfg_we_i,
    input  logic [1:0]        cfg_sel_i,
    input  logic [REG_W-1:0]  cfg_wdata_i,
    output logic [N_PORT-1:0] pend_o,
    output logic [N_PORT-1:0] en_o,
    output logic [REG_W-1:0]  pend_pri_o,
    output logic [REG_W-1:0]  pend_sec_o
);

    localparam logic [REG_W-1:0] USED_BITS = bank_used_mask(1'b1) | bank_used_mask(1'b0);

    cfg_sel_e          sel;
    logic [N_PORT-1:0] pend_q, en_q;
    logic [N_PORT-1:0] wr_clr, wr_en_pri, wr_en_sec, en_d;
    logic              wdata_unused;

    assign sel          = cfg_sel_e'(cfg_sel_i);
    assign wdata_unused = ^(cfg_wdata_i & ~USED_BITS);

    // Decode the core write into per-port strobes.
    always_comb begin
        wr_clr    = '0;
        wr_en_pri = '0;
        wr_en_sec = '0;
        en_d      = en_q;
        for (int p = 0; p < N_PORT; p++) begin
            if (port_in_primary(p)) begin
                wr_clr[p]    = cfg_we_i && (sel == CFG_CLR_PRI) && cfg_wdata_i[port_bit(p)];
                wr_en_pri[p] = cfg_we_i && (sel == CFG_EN_PRI);
            end else begin
                wr_clr[p]    = cfg_we_i && (sel == CFG_CLR_SEC) && cfg_wdata_i[port_bit(p)];
                wr_en_sec[p] = cfg_we_i && (sel == CFG_EN_SEC);
            end
            if (wr_en_pri[p] || wr_en_sec[p]) en_d[p] = cfg_wdata_i[port_bit(p)];
        end
    end

    // Set wins over clear: a new event is never lost.
    always_ff @(posedge clk_i) begin
        if (rst_i) begin
            pend_q <= '0;
            en_q   <= '0;
        end else begin
            pend_q <= (pend_q & ~(wr_clr | ack_clr_i)) | port_ev_i;
            en_q   <= en_d;
        end
    end

    assign pend_o = pend_q;
    assign en_o   = en_q;

    always_comb begin
        pend_pri_o = '0;
        pend_sec_o = '0;
        for (int p = 0; p < N_PORT; p++) begin
            if (port_in_primary(p)) pend_pri_o[port_bit(p)] = pend_q[p];
            else                    pend_sec_o[port_bit(p)] = pend_q[p];
        end
    end

    AST_ALL_EVENTS_LATCHED: assert property (@(posedge clk_i) disable iff (rst_i)
        (port_ev_i != '0) |=> ((pend_q & $past(port_ev_i)) == $past(port_ev_i))); // R7

    AST_CLEAR_TAKES: assert property (@(posedge clk_i) disable iff (rst_i)
        (((wr_clr | ack_clr_i) & ~port_ev_i) != '0)
        |=> ((pend_q & $past((wr_clr | ack_clr_i) & ~port_ev_i)) == '0)); // R10

endmodule

// File: rtl/dirq_prio_pick.sv
module dirq_prio_pick
    import dirq_pkg::*;
(
    input  logic [N_PORT-1:0]     cand_i,
    output logic                  found_o,
    output logic [PORT_IDX_W-1:0] pick_o,
    output logic [VEC_W-1:0]      vec_o
);

    logic [VEC_W-1:0] best;

    // Lowest vector among serviceable ports wins.
    always_comb begin
        found_o = 1'b0;
        pick_o  = '0;
        best    = '1;
        for (int p = 0; p < N_PORT; p++) begin
            if (cand_i[p] && (port_vec(p) < best)) begin
                found_o = 1'b1;
                best    = port_vec(p);
                pick_o  = PORT_IDX_W'(p);
            end
        end
        vec_o = best;
    end

endmodule

// File: rtl/serial_dma_irq_latch.sv
module serial_dma_irq_latch
    import dirq_pkg::*;
(
    input  logic                    clk_i,
    input  logic                    rst_i,
    input  logic [N_CHAN-1:0]       dma_mode_i,
    input  logic [N_CHAN-1:0]       done_i,
    input  logic [N_CHAN-1:0]       chain_ien_i,
    input  logic [N_CHAN-1:0]       rx_avail_i,
    input  logic [N_CHAN-1:0]       tx_room_i,
    input  logic                    cfg_we_i,
    input  logic [1:0]              cfg_sel_i,
    input  logic [REG_W-1:0]        cfg_wdata_i,
    input  logic                    ack_i,
    output logic                    irq_o,
    output logic [VEC_W-1:0]        irq_vec_o,
    output logic [REG_W-1:0]        pend_pri_o,
    output logic [REG_W-1:0]        pend_sec_o
);

    logic [N_PORT-1:0]     port_ev, pend, en, cand, ack_clr;
    logic                  found;
    logic [PORT_IDX_W-1:0] pick, req_port_q;
    logic [VEC_W-1:0]      pick_vec, vec_q;
    logic                  irq_q;
    req_state_e            state_q, state_n;

    dirq_event_merge u_merge (
        .clk_i       (clk_i),
        .rst_i       (rst_i),
        .dma_mode_i  (dma_mode_i),
        .done_i      (done_i),
        .chain_ien_i (chain_ien_i),
        .rx_avail_i  (rx_avail_i),
        .tx_room_i   (tx_room_i),
        .port_ev_o   (port_ev)
    );

    dirq_pending u_pend (
        .clk_i       (clk_i),
        .rst_i       (rst_i),
        .port_ev_i   (port_ev),
        .ack_clr_i   (ack_clr),
        .cfg_we_i    (cfg_we_i),
        .cfg_sel_i   (cfg_sel_i),
        .cfg_wdata_i (cfg_wdata_i),
        .pend_o      (pend),
        .en_o        (en),
        .pend_pri_o  (pend_pri_o),
        .pend_sec_o  (pend_sec_o)
    );

    assign cand = pend & en;

    dirq_prio_pick u_pick (
        .cand_i  (cand),
        .found_o (found),
        .pick_o  (pick),
        .vec_o   (pick_vec)
    );

    // Next-state logic.
    always_comb begin
        state_n = state_q;
        unique case (state_q)
            S_IDLE: if (found) state_n = S_REQ;
            S_REQ: begin
                if (ack_i)                  state_n = S_GAP;
                else if (!cand[req_port_q]) state_n = S_IDLE;
            end
            S_GAP:   state_n = S_IDLE;
            default: state_n = S_IDLE;
        endcase
    end

    // State register.
    always_ff @(posedge clk_i) begin
        if (rst_i) state_q <= S_IDLE;
        else       state_q <= state_n;
    end

    // Registered outputs and captured winner.
    always_ff @(posedge clk_i) begin
        if (rst_i) begin
            irq_q      <= 1'b0;
            vec_q      <= '0;
            req_port_q <= '0;
        end else begin
            irq_q <= (state_n == S_REQ);
            if ((state_q == S_IDLE) && found) begin
                vec_q      <= pick_vec;
                req_port_q <= pick;
            end
        end
    end

    always_comb begin
        ack_clr = '0;
        if ((state_q == S_REQ) && ack_i) ack_clr[req_port_q] = 1'b1;
    end

    assign irq_o     = irq_q;
    assign irq_vec_o = vec_q;

    AST_REQ_LATENCY: assert property (@(posedge clk_i) disable iff (rst_i)
        ((state_q == S_IDLE) && (cand != '0)) |=> irq_o); // R11

    AST_VEC_HOLD: assert property (@(posedge clk_i) disable iff (rst_i)
        (irq_o && !ack_i && cand[req_port_q]) |=> (irq_o && $stable(irq_vec_o))); // R12

    AST_ACK_DROPS: assert property (@(posedge clk_i) disable iff (rst_i)
        (irq_o && ack_i) |=> (!irq_o && !pend[$past(req_port_q)])); // R9

    AST_NO_IDLE_REQ: assert property (@(posedge clk_i) disable iff (rst_i)
        ((state_q != S_REQ) && (cand == '0)) |=> !irq_o); // R4

endmodule

// File: tb/serial_dma_irq_latch_bench.sv
module serial_dma_irq_latch_bench;

    logic        clk = 1'b0;
    logic        rst;
    logic [11:0] dma_mode, done, cien, rx, tx;
    logic        cfg_we, ack;
    logic [1:0]  cfg_sel;
    logic [31:0] cfg_wdata, pend_pri, pend_sec;
    logic        irq;
    logic [7:0]  vec;

    int checks = 0;
    int fails  = 0;
    bit auto_ack = 1'b0;
    bit done_flag = 1'b0;
    logic [7:0] exp_q[$];

    always #4 clk = ~clk;

    serial_dma_irq_latch u_serial_dma_irq_latch (
        .clk_i(clk), .rst_i(rst), .dma_mode_i(dma_mode), .done_i(done),
        .chain_ien_i(cien), .rx_avail_i(rx), .tx_room_i(tx),
        .cfg_we_i(cfg_we), .cfg_sel_i(cfg_sel), .cfg_wdata_i(cfg_wdata),
        .ack_i(ack), .irq_o(irq), .irq_vec_o(vec),
        .pend_pri_o(pend_pri), .pend_sec_o(pend_sec)
    );

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
        end
    endtask

    task automatic step();
        @(negedge clk);
    endtask

    task automatic cfg(input logic [1:0] sel, input logic [31:0] d);
        cfg_we = 1'b1; cfg_sel = sel; cfg_wdata = d;
        step();
        cfg_we = 1'b0; cfg_wdata = '0;
    endtask

    task automatic pulse(input logic [11:0] m, input logic [11:0] ien);
        done = m; cien = ien;
        step();
        done = '0;
    endtask

    task automatic clear_all();
        cfg(2'd2, 32'hFFFF_FFFF);
        cfg(2'd3, 32'hFFFF_FFFF);
    endtask

    // Expected position from R2: pair k -> port, port -> bank/bit.
    function automatic logic [63:0] exp_words(input int c);
        int k, p;
        logic [31:0] pri, sec;
        k = c / 2;
        p = (k % 2 == 0) ? k + 1 : k - 1;
        pri = '0; sec = '0;
        if (p % 2 == 1) pri[14 + p / 2] = 1'b1;
        else            sec[p / 2]      = 1'b1;
        return {pri, sec};
    endfunction

    // Scoreboard monitor: compares offered vectors and acknowledges them.
    always @(negedge clk) begin
        if (auto_ack) begin
            if (irq && !ack) begin
                if (exp_q.size() == 0) begin
                    chk("R8 unexpected request", {24'h0, vec}, 32'h0);
                end else begin
                    chk("R8 service order", {24'h0, vec}, {24'h0, exp_q.pop_front()});
                end
                ack = 1'b1;
            end else begin
                ack = 1'b0;
            end
        end
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done_flag) begin
            fails++;
            checks++;
            $display("FAIL watchdog actual=hung expected=finish");
            $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    end

    initial begin
        logic [63:0] w;
        rst = 1'b1; dma_mode = '1; done = '0; cien = '1; rx = '0; tx = '0;
        cfg_we = 1'b0; cfg_sel = '0; cfg_wdata = '0; ack = 1'b0;
        repeat (3) step();
        rst = 1'b0;
        step();

        // R1: reset state
        chk("R1 pend_pri", pend_pri, 0);
        chk("R1 pend_sec", pend_sec, 0);
        chk("R1 irq", {31'h0, irq}, 0);

        // R4: latched while masked, no request
        pulse(12'h001, '1);
        chk("R4 latched while masked", pend_pri, 32'h1 << 14);
        repeat (3) step();
        chk("R1 R4 masked no irq", {31'h0, irq}, 0);

        // R11: unmask -> request one cycle later
        cfg(2'd0, 32'h1 << 14);
        chk("R11 irq not yet", {31'h0, irq}, 0);
        step();
        chk("R11 irq rises", {31'h0, irq}, 1);
        chk("R3 vector port1", {24'h0, vec}, 32'h38);

        // R9: manual acknowledge
        ack = 1'b1; step(); ack = 1'b0;
        chk("R9 pending cleared", pend_pri, 0);
        chk("R9 irq dropped", {31'h0, irq}, 0);
        cfg(2'd0, 0);

        // R2, R10: channel mapping and clear writes
        for (int c = 0; c < 12; c++) begin
            pulse(12'(1 << c), '1);
            w = exp_words(c);
            chk($sformatf("R2 ch%0d primary", c), pend_pri, w[63:32]);
            chk($sformatf("R2 ch%0d secondary", c), pend_sec, w[31:0]);
            clear_all();
            chk($sformatf("R10 ch%0d cleared", c), pend_pri | pend_sec, 0);
        end

        // R5: chained descriptor enable
        pulse(12'h010, ~12'h010);
        chk("R5 suppressed completion", pend_pri, 0);
        pulse(12'h020, '1);
        chk("R5 enabled completion", pend_pri, 32'h1 << 15);
        clear_all();

        // R6: core-driven mode on channel 7 (port 2, secondary bit 1)
        dma_mode[7] = 1'b0;
        rx[7] = 1'b1; step(); rx[7] = 1'b0;
        chk("R6 rx available", pend_sec, 32'h2);
        clear_all();
        tx[7] = 1'b1; step(); tx[7] = 1'b0;
        chk("R6 tx room", pend_sec, 32'h2);
        clear_all();
        pulse(12'h080, '1);
        chk("R6 done ignored", pend_sec, 0);
        dma_mode[7] = 1'b1;

        // R10: event in the same cycle as its clear
        dma_mode[9] = 1'b0;
        rx[9] = 1'b1; step();
        cfg(2'd2, 32'h1 << 16);
        chk("R10 set wins over clear", pend_pri, 32'h1 << 16);
        rx[9] = 1'b0;
        cfg(2'd2, 32'h1 << 16);
        chk("R10 clear after level drops", pend_pri, 0);
        dma_mode[9] = 1'b1;

        // R12: hold and withdrawal
        cfg(2'd0, 32'h1 << 14);
        pulse(12'h002, '1);
        step();
        chk("R11 request after event", {31'h0, irq}, 1);
        repeat (2) step();
        chk("R12 still requesting", {31'h0, irq}, 1);
        chk("R12 vector held", {24'h0, vec}, 32'h38);
        cfg(2'd2, 32'h1 << 14);
        step();
        chk("R12 withdrawn", {31'h0, irq}, 0);
        cfg(2'd0, 0);

        // R7, R8: all ports at once, served by ascending vector
        cfg(2'd0, 32'h7 << 14);
        cfg(2'd1, 32'h7);
        exp_q = '{8'h38, 8'h3C, 8'h40, 8'h44, 8'h48, 8'h4C};
        auto_ack = 1'b1;
        pulse(12'hFFF, '1);
        chk("R7 primary all latched", pend_pri, 32'h7 << 14);
        chk("R7 secondary all latched", pend_sec, 32'h7);
        for (int i = 0; i < 100 && (exp_q.size() != 0 || irq); i++) step();
        repeat (2) step();
        chk("R8 all served", exp_q.size(), 0);
        chk("R9 nothing left", pend_pri | pend_sec, 0);

        // R8: mixed modes, three ports together
        exp_q = '{8'h3C, 8'h44, 8'h4C};
        dma_mode[2] = 1'b0;
        rx[2] = 1'b1; done = 12'h410; cien = '1;
        step();
        rx[2] = 1'b0; done = '0;
        for (int i = 0; i < 100 && (exp_q.size() != 0 || irq); i++) step();
        repeat (2) step();
        chk("R8 mixed served", exp_q.size(), 0);
        chk("R9 mixed cleared", pend_pri | pend_sec, 0);
        auto_ack = 1'b0;

        done_flag = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

endmodule